// File: doc/BRIEF.md
# IrDA Transmit Pulse Shaper

This block sits between a UART transmitter and an infrared line driver. It takes the transmitter's NRZ serial bit and turns each bit cell into either nothing or one short pulse placed about the middle of the cell. That is the return-to-zero shape an infrared link expects. A bit cell is divided into sixteen phases by a sample-rate clock enable. The transmitter marks the start of every bit with a one-cycle strobe.

The incoming bit can first be inverted by a data-polarity control. After that, a zero bit produces a pulse and a one bit produces none. The pulse starts at phase 6 and lasts three phases, so it covers phases 6, 7 and 8. This is a full-cell pulse with its leading edge delayed and its trailing part cut off. The output is registered. A second control picks whether the active level at the driver is high or low. Between cells, when no strobe renews the cell, the line rests at its inactive level.

Top module: `irda_pulse_shaper`

## Requirements
- R1: While reset is asserted, and on the first clock after reset, `ir_out` is 0 and the block is idle.
- R2: On a clock where `bit_start` is 1, the block captures the effective bit `nrz_bit ^ data_inv`. If the effective bit is 0 the cell carries a pulse. If it is 1 the cell carries no pulse, and `ir_out` stays at its inactive level for the whole cell.
- R3: In a pulse cell, `ir_out` is at its active level exactly while the phase count is PULSE_START to PULSE_START+PULSE_LEN-1 (6, 7 and 8 by default). That is from the clock after the tick that brings the phase to 6, up to and including the clock of the tick that brings it to 9. With one tick every T clocks, this lasts 3*T clocks.
- R4: The phase count is set to 0 by `bit_start`, which takes priority over a tick in the same cycle. Otherwise the count advances by one only on a clock where `tick` is 1.
- R5: A tick at phase CELL-1 (15) with no `bit_start` ends the cell. From then on `ir_out` holds its inactive level and the phase stops advancing until the next `bit_start`.
- R6: `out_inv` sets the levels: the active level is `!out_inv` and the inactive level is `out_inv`. A change of `out_inv` appears on `ir_out` one clock later.
- R7: A `bit_start` in the middle of a cell abandons that cell. Phase timing restarts from 0 with the newly captured bit, and a pulse already in progress is cut off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample-rate enable, CELL ticks per bit |
| bit_start | input | 1 | One-cycle strobe at the start of each bit cell |
| nrz_bit | input | 1 | NRZ data bit from the transmitter, sampled with `bit_start` |
| data_inv | input | 1 | Inverts the data bit before shaping |
| out_inv | input | 1 | 1 selects an active-low pulse on the output |
| ir_out | output | 1 | Shaped pulse to the infrared driver |

## Verification
The bench builds the block with its default parameters: sixteen phases per cell and a three-phase pulse starting at phase 6. It drives the tick once every four clocks, so each phase spans several clocks. That makes an edge that is one clock early or late, or a window that is one phase wide off, visible at the output. It also places strobes on and off the tick grid, restarts cells in mid-pulse, leaves idle gaps after the last phase, and flips both polarity controls between bits.

// File: rtl/irda_pulse_shaper.sv
module irda_pulse_shaper #(
  parameter int CELL        = 16,
  parameter int PULSE_START = 6,
  parameter int PULSE_LEN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bit_start,
  input  logic nrz_bit,
  input  logic data_inv,
  input  logic out_inv,
  output logic ir_out
);
  localparam int PW = (CELL > 1) ? $clog2(CELL) : 1;
  localparam logic [PW-1:0] LAST_PH = PW'(CELL - 1);
  localparam logic [PW-1:0] WIN_LO  = PW'(PULSE_START);
  localparam logic [PW:0]   WIN_HI  = (PW+1)'(PULSE_START + PULSE_LEN);

  logic [PW-1:0] phase, phase_nx;
  logic          busy, busy_nx;
  logic          bit_zero, bit_zero_nx;
  logic          active_nx;

  always_comb begin
    phase_nx    = phase;
    busy_nx     = busy;
    bit_zero_nx = bit_zero;
    if (bit_start) begin
      phase_nx    = '0;
      busy_nx     = 1'b1;
      bit_zero_nx = ~(nrz_bit ^ data_inv);
    end else if (tick && busy) begin
      if (phase == LAST_PH) busy_nx = 1'b0;
      else                  phase_nx = phase + 1'b1;
    end
  end

  assign active_nx = busy_nx && bit_zero_nx &&
                     (phase_nx >= WIN_LO) && ({1'b0, phase_nx} < WIN_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      busy     <= 1'b0;
      bit_zero <= 1'b0;
      ir_out   <= 1'b0;
    end else begin
      phase    <= phase_nx;
      busy     <= busy_nx;
      bit_zero <= bit_zero_nx;
      ir_out   <= active_nx ^ out_inv;
    end
  end
endmodule

// File: rtl/irda_pulse_shaper_chk.sv
module irda_pulse_shaper_chk #(
  parameter int CELL        = 16,
  parameter int PULSE_START = 6,
  parameter int PULSE_LEN   = 3,
  parameter int PW          = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          bit_start,
  input logic          out_inv,
  input logic          ir_out,
  input logic [PW-1:0] phase,
  input logic          busy,
  input logic          bit_zero
);
  logic was_run;
  always_ff @(posedge clk) was_run <= rst_n;

  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !ir_out); // R1

  AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> (phase == '0) && busy); // R4

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_start && !tick) |=> $stable(phase)); // R4

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_start && tick && busy && (int'(phase) != CELL - 1)) |=>
    (int'(phase) == int'($past(phase)) + 1)); // R4

  AST_ACTIVE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && (ir_out != $past(out_inv))) |->
    (busy && bit_zero && int'(phase) >= PULSE_START &&
     int'(phase) < PULSE_START + PULSE_LEN)); // R3

  AST_ONE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && !bit_zero) |-> (ir_out == $past(out_inv))); // R2

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (was_run && !busy) |-> (ir_out == $past(out_inv))); // R5
endmodule

bind irda_pulse_shaper irda_pulse_shaper_chk #(
  .CELL(CELL), .PULSE_START(PULSE_START), .PULSE_LEN(PULSE_LEN), .PW(PW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bit_start(bit_start),
  .out_inv(out_inv), .ir_out(ir_out), .phase(phase), .busy(busy),
  .bit_zero(bit_zero)
);

// File: tb/irda_pulse_shaper_tb.sv
`timescale 1ns/1ps
module irda_pulse_shaper_tb_top;
  localparam int CELL = 16;
  localparam int PST  = 6;
  localparam int PLEN = 3;
  localparam int TDIV = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic tick = 0, bit_start = 0, nrz_bit = 1, data_inv = 0, out_inv = 0;
  logic ir_out;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit tick_en = 0;

  int  m_ph = 0;
  bit  m_busy = 0, m_zero = 0, m_out = 0;

  irda_pulse_shaper #(.CELL(CELL), .PULSE_START(PST), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bit_start(bit_start),
    .nrz_bit(nrz_bit), .data_inv(data_inv), .out_inv(out_inv), .ir_out(ir_out)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: ir_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_busy = 0; m_zero = 0; m_out = 0;
    end else begin
      if (bit_start) begin
        m_ph = 0; m_busy = 1; m_zero = ((nrz_bit ^ data_inv) == 0);
      end else if (tick && m_busy) begin
        if (m_ph == CELL - 1) m_busy = 0;
        else m_ph++;
      end
      m_out = (m_busy && m_zero && m_ph >= PST && m_ph < PST + PLEN) ^ out_inv;
    end
  end

  always @(negedge clk) check(cur_req, ir_out, m_out);

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt + 1) % TDIV;
      tick = tick_en && (cnt == 0);
    end
  end

  task automatic strobe(bit b);
    @(negedge clk);
    nrz_bit = b; bit_start = 1;
    @(negedge clk);
    bit_start = 0;
  endtask

  task automatic send_bit(bit b, output int act_cnt);
    act_cnt = 0;
    strobe(b);
    for (int i = 0; i < CELL * TDIV - 1; i++) begin
      @(negedge clk);
      if (ir_out != out_inv) act_cnt++;
    end
  endtask

  bit done = 0;
  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    check("R1", ir_out, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1", ir_out, 1'b0);
    tick_en = 1;
    repeat (10) @(negedge clk);

    cur_req = "R3";
    send_bit(0, c);
    n_cmp++; if (c != PLEN * TDIV) begin n_bad++; $display("FAIL R3: active clocks=%0d expected %0d", c, PLEN*TDIV); end
    cur_req = "R2";
    send_bit(1, c);
    n_cmp++; if (c != 0) begin n_bad++; $display("FAIL R2: active clocks=%0d expected 0", c); end
    data_inv = 1;
    send_bit(1, c);
    n_cmp++; if (c != PLEN * TDIV) begin n_bad++; $display("FAIL R2: inverted one gave %0d expected %0d", c, PLEN*TDIV); end
    data_inv = 0;

    cur_req = "R6";
    out_inv = 1;
    @(negedge clk);
    send_bit(0, c);
    n_cmp++; if (c != PLEN * TDIV) begin n_bad++; $display("FAIL R6: active-low clocks=%0d expected %0d", c, PLEN*TDIV); end
    send_bit(1, c);
    out_inv = 0;

    cur_req = "R5";
    repeat (3 * TDIV * CELL) @(negedge clk);
    check("R5", ir_out, out_inv);

    cur_req = "R4";
    for (int k = 0; k < 6; k++) begin
      repeat (k) @(negedge clk);
      send_bit(k[0], c);
    end

    cur_req = "R7";
    for (int k = 0; k < 5; k++) begin
      strobe(0);
      repeat (PST * TDIV + k * 3) @(negedge clk);
      strobe(k[1]);
      repeat (20 + k) @(negedge clk);
    end
    repeat (CELL * TDIV + 8) @(negedge clk);

    cur_req = "R6";
    strobe(0);
    for (int k = 0; k < CELL * TDIV; k++) begin
      @(negedge clk);
      if (k % 7 == 0) out_inv = ~out_inv;
    end
    out_inv = 0;
    repeat (CELL * TDIV) @(negedge clk);

    cur_req = "R1";
    rst_n = 0;
    strobe(0);
    repeat (3) @(negedge clk);
    check("R1", ir_out, 1'b0);
    rst_n = 1;
    repeat (8) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule